// File: doc/BRIEF.md
# Min-Sum Check Node Unit

This block is the check-side processor of a regular low-density parity-check decoder whose parity rows each connect six variable nodes. Each accepted cycle it reads six variable-to-check messages and returns six check-to-variable messages. Output lane i leaves out input i: its magnitude is the smallest magnitude among the other five lanes, and its sign is the parity of the other five signs. This is the min-sum update.

Messages are 5-bit two's-complement fixed-point numbers. The format is one sign bit, two integer bits and two fraction bits, so one LSB equals 0.25. At the input the unit converts each message to sign and 4-bit magnitude. It then finds the smallest magnitude, the second-smallest magnitude and the lane that holds the smallest. Each result is converted back to two's complement and registered. The unit has one register stage, and a valid flag travels with the data.

Top module: `cnu_minsum_core`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous clock, and a synchronous active-low reset clears it to 0.
- R2: The magnitude of output lane i equals the minimum magnitude over all input lanes except lane i.
- R3: The sign of output lane i is the XOR of the sign bits (bit 4) of all input lanes except lane i.
- R4: Lane k occupies bits [5k+4:5k] on both buses, in two's complement. An output of magnitude 0 is always 5'b00000, whatever its sign, so no output is ever 5'b10000.
- R5: An input of -16 (5'b10000) is treated as magnitude 15.
- R6: When several lanes share the smallest magnitude, every lane receives that smallest value, including each of the tied lanes.
- R7: While `in_valid` is low, `out_msgs` keeps its previous value. Reset clears `out_msgs` to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input messages are valid this cycle |
| in_msgs | input | 30 | Six 5-bit variable-to-check messages |
| out_valid | output | 1 | Output messages are valid |
| out_msgs | output | 30 | Six 5-bit check-to-variable messages |

## Verification
The bench applies a message set before a rising edge and expects `out_valid` and all six output lanes exactly one edge later. It therefore drives on the falling edge and compares on the next falling edge, after the single register stage has loaded. The hold behaviour is also judged one edge after an idle cycle: the lanes must still show the previous result and `out_valid` must be low. The reset state is read on the falling edge that follows the first reset edge.

// File: rtl/cnu_pkg.sv
// Shared widths for the min-sum check node unit.
// Assumes a 5-bit message: sign, 2 integer bits and 2 fraction bits.
package cnu_pkg;
    localparam int MSG_W = 5;
    localparam int MAG_W = MSG_W - 1;
    localparam int DEG   = 6;
    localparam int IDX_W = $clog2(DEG);
endpackage

// File: rtl/cnu_to_sm.sv
// Converts one two's-complement message to sign and magnitude.
// Assumes the most negative code saturates to the largest magnitude.
module cnu_to_sm #(
    parameter int MSG_W = 5,
    localparam int MAG_W = MSG_W - 1
) (
    input  logic [MSG_W-1:0] msg,
    output logic             sgn,
    output logic [MAG_W-1:0] mag
);
    logic [MSG_W-1:0] negated;
    logic             is_most_neg;

    // Split sign and absolute value, saturating the lone unpaired code.
    always_comb begin
        negated     = (~msg) + MSG_W'(1);
        is_most_neg = (msg == {1'b1, {MAG_W{1'b0}}});
        sgn         = msg[MSG_W-1];
        if (is_most_neg)
            mag = {MAG_W{1'b1}};
        else if (msg[MSG_W-1])
            mag = negated[MAG_W-1:0];
        else
            mag = msg[MAG_W-1:0];
    end
endmodule

// File: rtl/cnu_from_sm.sv
// Converts a sign and magnitude pair back to two's complement.
// Assumes a zero magnitude always yields +0 whatever the sign.
module cnu_from_sm #(
    parameter int MSG_W = 5,
    localparam int MAG_W = MSG_W - 1
) (
    input  logic             sgn,
    input  logic [MAG_W-1:0] mag,
    output logic [MSG_W-1:0] msg
);
    logic [MSG_W-1:0] wide;

    // Negate the zero-extended magnitude when the sign is set and non-zero.
    always_comb begin
        wide = {1'b0, mag};
        if (sgn && (mag != '0))
            msg = (~wide) + MSG_W'(1);
        else
            msg = wide;
    end
endmodule

// File: rtl/cnu_min2.sv
// Finds the smallest and second-smallest of DEG magnitudes and the
// lane holding the smallest. Assumes ties go to the lowest lane index.
module cnu_min2 #(
    parameter int DEG   = 6,
    parameter int MAG_W = 4,
    localparam int IDX_W = $clog2(DEG)
) (
    input  logic [DEG*MAG_W-1:0] mags,
    output logic [MAG_W-1:0]     min1,
    output logic [MAG_W-1:0]     min2,
    output logic [IDX_W-1:0]     min1_idx
);
    logic [MAG_W-1:0] cur;

    // Linear scan; a strict compare keeps the earliest lane on ties.
    always_comb begin
        min1     = mags[MAG_W-1:0];
        min2     = {MAG_W{1'b1}};
        min1_idx = '0;
        cur      = '0;
        for (int i = 1; i < DEG; i++) begin
            cur = mags[i*MAG_W +: MAG_W];
            if (cur < min1) begin
                min2     = min1;
                min1     = cur;
                min1_idx = IDX_W'(i);
            end else if (cur < min2) begin
                min2 = cur;
            end
        end
    end
endmodule

// File: rtl/cnu_minsum_core.sv
// Min-sum check node unit: six messages in, six excluded-lane
// messages out, one register stage. Assumes synchronous active-low reset.
module cnu_minsum_core #(
    parameter int DEG   = cnu_pkg::DEG,
    parameter int MSG_W = cnu_pkg::MSG_W,
    localparam int MAG_W = MSG_W - 1,
    localparam int IDX_W = $clog2(DEG),
    localparam int BUS_W = DEG * MSG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] in_msgs,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_msgs
);
    logic [DEG-1:0]       in_sgn;
    logic [DEG*MAG_W-1:0] in_mag;
    logic [MAG_W-1:0]     min1, min2;
    logic [IDX_W-1:0]     min1_idx;
    logic                 sgn_all;
    logic [BUS_W-1:0]     next_msgs;

    // Per-lane input conversion and output assembly.
    for (genvar g = 0; g < DEG; g++) begin : g_lane
        logic [MAG_W-1:0] sel_mag;
        logic             sel_sgn;

        cnu_to_sm #(.MSG_W(MSG_W)) u_to_sm (
            .msg (in_msgs[g*MSG_W +: MSG_W]),
            .sgn (in_sgn[g]),
            .mag (in_mag[g*MAG_W +: MAG_W])
        );

        // Pick the second minimum for the lane that owns the minimum.
        always_comb begin
            sel_mag = (min1_idx == IDX_W'(g)) ? min2 : min1;
            sel_sgn = sgn_all ^ in_sgn[g];
        end

        cnu_from_sm #(.MSG_W(MSG_W)) u_from_sm (
            .sgn (sel_sgn),
            .mag (sel_mag),
            .msg (next_msgs[g*MSG_W +: MSG_W])
        );

        AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_msgs[g*MSG_W +: MSG_W] != {1'b1, {MAG_W{1'b0}}})); // R4
    end

    cnu_min2 #(.DEG(DEG), .MAG_W(MAG_W)) u_min2 (
        .mags     (in_mag),
        .min1     (min1),
        .min2     (min2),
        .min1_idx (min1_idx)
    );

    // Parity of all input signs, shared by every lane.
    always_comb sgn_all = ^in_sgn;

    // Output register stage with valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_msgs  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_msgs <= next_msgs;
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_msgs)); // R7
    AST_MIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (min1 <= min2)); // R2
    AST_MIN_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (in_mag[min1_idx*MAG_W +: MAG_W] == min1)); // R2
endmodule

// File: tb/cnu_minsum_core_tb.sv
module cnu_minsum_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEG = 6;
    localparam int MW  = 5;
    localparam int BW  = DEG * MW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [BW-1:0] in_msgs = '0;
    logic          out_valid;
    logic [BW-1:0] out_msgs;
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cnu_minsum_core u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_msgs(in_msgs), .out_valid(out_valid), .out_msgs(out_msgs)
    );

    function automatic int mag_of(logic [MW-1:0] v);
        int s;
        s = $signed(v);
        if (s < 0) s = -s;
        if (s > 15) s = 15;
        return s;
    endfunction

    function automatic logic [MW-1:0] exp_lane(logic [BW-1:0] m, int i);
        int   mn = 15;
        logic sg = 1'b0;
        int   r;
        for (int j = 0; j < DEG; j++) begin
            if (j != i) begin
                if (mag_of(m[j*MW +: MW]) < mn) mn = mag_of(m[j*MW +: MW]);
                sg = sg ^ m[j*MW + MW - 1];
            end
        end
        r = (sg && mn != 0) ? -mn : mn;
        return MW'(r);
    endfunction

    function automatic logic [BW-1:0] exp_bus(logic [BW-1:0] m);
        logic [BW-1:0] r;
        for (int i = 0; i < DEG; i++) r[i*MW +: MW] = exp_lane(m, i);
        return r;
    endfunction

    task automatic check(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one vector on the falling edge, compare on the next falling edge.
    task automatic apply(string tag, logic [BW-1:0] m);
        in_valid = 1'b1;
        in_msgs  = m;
        @(negedge clk);
        check({tag, " R1 valid"}, BW'(out_valid), BW'(1));
        check(tag, out_msgs, exp_bus(m));
    endtask

    function automatic logic [BW-1:0] all_same(logic [MW-1:0] v);
        return {DEG{v}};
    endfunction

    initial begin
        logic [BW-1:0] last;
        logic [BW-1:0] r;
        void'($urandom(32'd20240405));
        in_valid = 1'b1;
        in_msgs  = all_same(5'b00111);
        @(negedge clk);
        check("R1 reset valid", BW'(out_valid), BW'(0));
        check("R7 reset data", out_msgs, '0);
        rst_n = 1'b1;

        apply("R2 R3 R4 mixed", {5'b00011, 5'b11110, 5'b00101, 5'b11000, 5'b00110, 5'b01111});
        apply("R5 saturate all -16", all_same(5'b10000));
        apply("R5 single -16", {5'b10000, 5'b00111, 5'b01000, 5'b11001, 5'b01010, 5'b01011});
        apply("R6 tie at min", {5'b01100, 5'b00010, 5'b11110, 5'b00111, 5'b00101, 5'b01001});
        apply("R4 zero neg sign", {5'b11111, 5'b00000, 5'b00011, 5'b11101, 5'b00100, 5'b00101});
        apply("R3 all negative", all_same(5'b11101));
        apply("R2 min at lane 5", {5'b00001, 5'b01111, 5'b01110, 5'b01101, 5'b01100, 5'b01011});
        last = {5'b00001, 5'b01111, 5'b01110, 5'b01101, 5'b01100, 5'b01011};

        in_valid = 1'b0;
        in_msgs  = all_same(5'b11011);
        @(negedge clk);
        check("R1 idle valid", BW'(out_valid), BW'(0));
        check("R7 hold idle", out_msgs, exp_bus(last));

        for (int n = 0; n < 200; n++) begin
            for (int k = 0; k < DEG; k++) r[k*MW +: MW] = MW'($urandom);
            apply("R2 R3 R4 random", r);
        end

        rst_n = 1'b0;
        @(negedge clk);
        check("R7 reset again", out_msgs, '0);
        check("R1 reset again", BW'(out_valid), BW'(0));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule